// File: doc/BRIEF.md
# Multi-Level Priority Channel Arbiter

This block picks which one of eight transfer channels owns the data engine. Each channel raises a request bit and carries a two-bit priority tier. The arbiter grants the highest tier that has a pending request. Inside a tier it uses either the lowest channel number or a rotating order, and each tier's setting is chosen on its own. A granted channel keeps the engine until the controller reports the end of a transfer unit. The grant then returns to arbitration.

While a channel is running, the block watches for any request from a tier above the running channel. When it sees one, it emits a one-cycle preempt pulse and keeps the grant where it is. The controller saves the running channel's context and then acknowledges. The arbiter decides again in the acknowledge cycle, and the new grant appears on the following cycle.

The controller is a state machine with four named states:
- `ST_IDLE`: nothing is granted.
- `ST_RUN`: a channel is active.
- `ST_FLAG`: the single cycle that drives the preempt pulse.
- `ST_HOLD`: the old grant is held while the controller saves state.

Its transitions are:
- IDLE→RUN: any request is pending.
- RUN→RUN: unit done, and requests remain.
- RUN→IDLE: unit done, and no request remains.
- RUN→FLAG: a higher tier requests.
- FLAG→HOLD: no acknowledge yet.
- FLAG/HOLD→RUN: acknowledge, and requests are pending.
- FLAG/HOLD→IDLE: acknowledge, and nothing is pending.

Top module: `chan_arbiter`

## Requirements
- R1: After reset no channel is granted: `grant` is 0, `active_vld` is 0 and `preempt` is 0.
- R2: At most one `grant` bit is set. When `active_vld` is 1, `grant` bit `active_idx` is the one that is set.
- R3: Channel c takes its tier from `chan_lvl[2c+1:2c]`. Tier 3 is the highest and tier 0 the lowest. An arbitration always picks a channel from the highest tier that has a pending request.
- R4: When `tier_rr[t]` is 0, tier t is in fixed order: the lowest-numbered requesting channel of that tier wins.
- R5: When `tier_rr[t]` is 1, the search in tier t starts one channel after the channel last granted from that tier, wrapping from 7 to 0. The tier's pointer changes only when a grant from that tier is issued. After reset the search starts at channel 0.
- R6: A running grant stays unchanged until `unit_done`, or until a handover is acknowledged. Requests from the same tier or from a lower tier do not disturb it and produce no preempt.
- R7: A request from a tier above the running channel's tier makes `preempt` go high for exactly one cycle, one cycle after the request is seen. The old grant stays in place until `save_ack`.
- R8: When `save_ack` is high after a preempt, the arbiter decides in that cycle and the new grant is visible one cycle later.
- R9: A `unit_done` with no pending request leaves the block idle on the next cycle.
- R10: If `unit_done` and a higher-tier request fall in the same cycle, no preempt is issued. The higher-tier channel is granted directly on the next cycle.
- R11: From idle, a pending request is granted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 8 | Per-channel transfer request |
| chan_lvl | input | 16 | Per-channel tier, two bits per channel |
| tier_rr | input | 4 | Per-tier order select: 1 rotating, 0 fixed |
| unit_done | input | 1 | Active channel finished its transfer unit |
| save_ack | input | 1 | Controller finished saving state after a preempt |
| grant | output | 8 | One-hot grant |
| active_idx | output | 3 | Index of the granted channel |
| active_vld | output | 1 | A channel is granted |
| preempt | output | 1 | One-cycle request to hand the engine over |

## Verification
Two functions can collide in one cycle: the end of a transfer unit and the arrival of a higher-tier request. Both would move the grant, but by different paths. The bench provokes the collision by raising a tier-3 request on the same cycle as `unit_done` while a tier-0 channel runs. It judges the result by requiring that no preempt pulse appears and that the tier-3 channel holds the grant on the very next cycle.

// File: rtl/chan_arbiter_pkg.sv
package chan_arbiter_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FLAG = 2'd2,
        ST_HOLD = 2'd3
    } arb_state_e;
endpackage

// File: rtl/tier_picker.sv
module tier_picker #(
    parameter int NCH = 8,
    parameter int IW  = $clog2(NCH)
) (
    input  logic [NCH-1:0] cand,
    input  logic           rr_en,
    input  logic [IW-1:0]  last,
    output logic           hit,
    output logic [IW-1:0]  pick
);
    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 0; k < NCH; k++) begin
            if (!hit && cand[(rr_en ? (int'(last) + 1 + k) : k) % NCH]) begin
                hit  = 1'b1;
                pick = IW'((rr_en ? (int'(last) + 1 + k) : k) % NCH);
            end
        end
    end
endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter
    import chan_arbiter_pkg::*;
#(
    parameter int NCH  = 8,
    parameter int NLVL = 4,
    localparam int IW  = $clog2(NCH),
    localparam int LW  = $clog2(NLVL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    req,
    input  logic [NCH*LW-1:0] chan_lvl,
    input  logic [NLVL-1:0]   tier_rr,
    input  logic              unit_done,
    input  logic              save_ack,
    output logic [NCH-1:0]    grant,
    output logic [IW-1:0]     active_idx,
    output logic              active_vld,
    output logic              preempt
);
    arb_state_e state_q, state_d;

    logic [NCH-1:0] tier_mask [NLVL];
    logic [NLVL-1:0] tier_hit;
    logic [IW-1:0]  tier_pick [NLVL];
    logic [IW-1:0]  rr_last   [NLVL];
    logic [IW-1:0]  act_q;

    logic           any_req;
    logic [IW-1:0]  win_idx;
    logic [LW-1:0]  win_lvl;
    logic [LW-1:0]  cur_lvl;
    logic           higher;
    logic           fire;

    // per-tier candidate masks and pickers
    for (genvar t = 0; t < NLVL; t++) begin : g_tier
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign tier_mask[t][c] = req[c] && (chan_lvl[c*LW +: LW] == LW'(t));
        end
        tier_picker #(.NCH(NCH), .IW(IW)) u_pick (
            .cand  (tier_mask[t]),
            .rr_en (tier_rr[t]),
            .last  (rr_last[t]),
            .hit   (tier_hit[t]),
            .pick  (tier_pick[t])
        );
    end

    // highest tier with a request wins
    always_comb begin
        any_req = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int t = 0; t < NLVL; t++) begin
            if (tier_hit[t]) begin
                any_req = 1'b1;
                win_idx = tier_pick[t];
                win_lvl = LW'(t);
            end
        end
    end

    // is some tier above the running channel requesting
    always_comb begin
        cur_lvl = chan_lvl[int'(act_q)*LW +: LW];
        higher  = 1'b0;
        for (int t = 0; t < NLVL; t++) begin
            if (tier_hit[t] && (LW'(t) > cur_lvl)) higher = 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        fire    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                fire = any_req;
                if (any_req) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (unit_done) begin
                    fire    = 1'b1;
                    state_d = any_req ? ST_RUN : ST_IDLE;
                end else if (higher) begin
                    state_d = ST_FLAG;
                end
            end
            ST_FLAG, ST_HOLD: begin
                if (save_ack) begin
                    fire    = 1'b1;
                    state_d = any_req ? ST_RUN : ST_IDLE;
                end else begin
                    state_d = ST_HOLD;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // grant index and rotation pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
            for (int t = 0; t < NLVL; t++) rr_last[t] <= IW'(NCH - 1);
        end else if (fire && any_req) begin
            act_q            <= win_idx;
            rr_last[win_lvl] <= win_idx;
        end
    end

    // outputs
    always_comb begin
        active_vld = (state_q != ST_IDLE);
        active_idx = act_q;
        preempt    = (state_q == ST_FLAG);
        grant      = '0;
        if (active_vld) grant[act_q] = 1'b1;
    end
endmodule

// File: rtl/chan_arbiter_chk.sv
module chan_arbiter_chk #(
    parameter int NCH = 8,
    localparam int IW = $clog2(NCH)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           unit_done,
    input logic           save_ack,
    input logic [NCH-1:0] grant,
    input logic [IW-1:0]  active_idx,
    input logic           active_vld,
    input logic           preempt
);
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R2
    AST_IDX_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        active_vld |-> grant[active_idx]); // R2
    AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (active_vld && !unit_done && !save_ack) |=> $stable(grant)); // R6
    AST_PREEMPT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |=> !preempt); // R7
    AST_PREEMPT_FROM_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        preempt |-> $past(active_vld)); // R7
    AST_IDLE_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
        !active_vld |=> !preempt); // R7
endmodule

bind chan_arbiter chan_arbiter_chk #(.NCH(NCH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .unit_done  (unit_done),
    .save_ack   (save_ack),
    .grant      (grant),
    .active_idx (active_idx),
    .active_vld (active_vld),
    .preempt    (preempt)
);

// File: tb/chan_arbiter_tb.sv
`timescale 1ns/1ps
module chan_arbiter_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  req = '0;
    logic [15:0] chan_lvl = '0;
    logic [3:0]  tier_rr = '0;
    logic        unit_done = 1'b0;
    logic        save_ack = 1'b0;
    logic [7:0]  grant;
    logic [2:0]  active_idx;
    logic        active_vld;
    logic        preempt;

    int nchk = 0;
    int nfail = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    chan_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .chan_lvl(chan_lvl),
        .tier_rr(tier_rr), .unit_done(unit_done), .save_ack(save_ack),
        .grant(grant), .active_idx(active_idx), .active_vld(active_vld),
        .preempt(preempt)
    );

    task automatic chk(string tag, int act, int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_grant(string tag, int ch);
        chk({tag, " vld"}, int'(active_vld), 1);
        chk({tag, " idx"}, int'(active_idx), ch);
        chk({tag, " grant"}, int'(grant), 1 << ch);
    endtask

    task automatic set_lvl(int ch, int l);
        chan_lvl[ch*2 +: 2] = 2'(l);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req = '0; unit_done = 1'b0; save_ack = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_done();
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 grant", int'(grant), 0);
        chk("R1 vld", int'(active_vld), 0);
        chk("R1 preempt", int'(preempt), 0);
    endtask

    task automatic t_tiers();
        do_reset();
        chan_lvl = '0; tier_rr = '0;
        set_lvl(1, 0); set_lvl(5, 2); set_lvl(6, 1); set_lvl(2, 2);
        req = 8'b0110_0010;
        @(negedge clk);
        chk_grant("R11 R3 highest tier", 5);
        // same tier request must not disturb
        req[2] = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R6 no preempt same tier", int'(preempt), 0);
        end
        chk_grant("R6 held", 5);
        req = '0;
        pulse_done();
        chk("R9 idle vld", int'(active_vld), 0);
        chk("R9 idle grant", int'(grant), 0);
    endtask

    task automatic t_fixed();
        do_reset();
        chan_lvl = {8{2'd1}}; tier_rr = '0;
        req = 8'b0100_1000;
        @(negedge clk);
        chk_grant("R4 fixed lowest", 3);
        pulse_done();
        chk_grant("R4 fixed again", 3);
        req = '0;
        pulse_done();
    endtask

    task automatic t_rr();
        do_reset();
        chan_lvl = {8{2'd1}}; tier_rr = 4'b0010;
        req = 8'b0101_0100;
        @(negedge clk);
        chk_grant("R5 rr first", 2);
        pulse_done();
        chk_grant("R5 rr second", 4);
        pulse_done();
        chk_grant("R5 rr third", 6);
        pulse_done();
        chk_grant("R5 rr wrap", 2);
        req = '0;
        pulse_done();
    endtask

    task automatic t_preempt();
        do_reset();
        chan_lvl = '0; tier_rr = '0;
        set_lvl(0, 0); set_lvl(4, 3);
        req = 8'b0000_0001;
        @(negedge clk);
        chk_grant("R11 low start", 0);
        req[4] = 1'b1;
        @(negedge clk);
        chk("R7 preempt high", int'(preempt), 1);
        chk_grant("R7 old kept", 0);
        @(negedge clk);
        chk("R7 preempt one cycle", int'(preempt), 0);
        chk_grant("R7 held before ack", 0);
        save_ack = 1'b1;
        @(negedge clk);
        save_ack = 1'b0;
        chk_grant("R8 new after ack", 4);
        chk("R8 no preempt", int'(preempt), 0);
        req = '0;
        pulse_done();
    endtask

    task automatic t_collide();
        do_reset();
        chan_lvl = '0; tier_rr = '0;
        set_lvl(0, 0); set_lvl(4, 3);
        req = 8'b0000_0001;
        @(negedge clk);
        chk_grant("R10 start", 0);
        req[4] = 1'b1;
        unit_done = 1'b1;
        @(negedge clk);
        unit_done = 1'b0;
        chk("R10 no preempt", int'(preempt), 0);
        chk_grant("R10 direct grant", 4);
        @(negedge clk);
        chk("R10 still no preempt", int'(preempt), 0);
        req = '0;
        pulse_done();
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        t_reset();
        t_tiers();
        t_fixed();
        t_rr();
        t_preempt();
        t_collide();
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            summary();
            $finish;
        end
    end
endmodule